// File: doc/BRIEF.md
# Register Access Trap Filter

This block decides whether a guest read or write of a model-specific register has to be handed to the hypervisor. Each request carries a 32-bit register index, a direction flag, the base address of a 4 KB permission bitmap region and an enable for that bitmap scheme. When the scheme is off, or the index falls outside the two supported index windows, the answer is "trap" at once, with no memory traffic.

For an index inside a window, the block forms a byte address in the bitmap region, fetches that single byte over a simple request/acknowledge memory port, and traps when the bit picked by the low three index bits is set. The region holds four 1 KB quarters: low-window reads, high-window reads, low-window writes and high-window writes. The result leaves as a one-cycle done pulse with a trap flag. One request is in flight at a time; a request strobe seen while a fetch is pending is dropped.

Top module: `msr_trap_filter`

## Requirements
- R1: With `bitmaps_en_i` low, an accepted request produces `done_o` with `trap_o` high in the next cycle and no memory request.
- R2: An index in 0x00000000..0x00001FFF read access fetches the byte at `bitmap_base_i + index[12:3]`.
- R3: An index in 0xC0000000..0xC0001FFF fetches at `bitmap_base_i + 1024 + (index - 0xC0000000)[12:3]`.
- R4: A write access (`is_write_i` high) adds 2048 to the byte offset in either window; a read adds nothing.
- R5: `trap_o` equals bit `index[2:0]` of the fetched byte (bit 0 is the least significant).
- R6: An enabled request with index 0x00002000..0xBFFFFFFF or above 0xC0001FFF traps in the next cycle with no memory request.
- R7: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i` is sampled high; `done_o` rises in the cycle after that sample and `mem_req_o` drops.
- R8: A request strobe seen while a fetch is pending is ignored: it yields no done pulse and no memory read.
- R9: After reset `done_o`, `trap_o` and `mem_req_o` are low.
- R10: Each accepted request yields exactly one single-cycle `done_o` pulse, never while `mem_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Check request strobe, taken only when idle |
| index_i | input | 32 | Register index to check |
| is_write_i | input | 1 | 1 = write access, 0 = read access |
| bitmap_base_i | input | 32 | Byte address of the 4 KB bitmap region |
| bitmaps_en_i | input | 1 | Bitmap filtering enable; 0 traps everything |
| mem_req_o | output | 1 | Bitmap byte read request |
| mem_addr_o | output | 32 | Bitmap byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 8 | Fetched bitmap byte |
| done_o | output | 1 | One-cycle result strobe |
| trap_o | output | 1 | 1 = access must trap; valid with done_o |

## Verification
The bench drives the window edges 0x1FFF, 0x2000, 0xBFFFFFFF, 0xC0000000, 0xC0001FFF and 0xC0002000, where an off-by-one decode would either fetch a byte for an index that should trap outright or trap without consulting the bitmap. It mixes directions and windows with an unaligned base so that a swapped quarter offset or a dropped write offset reads the wrong byte and returns the wrong verdict. It varies acknowledge latency and strobes a second request during a pending fetch, which a design lacking the busy guard would answer twice or answer with the second index's bit.

// File: rtl/msr_trap_pkg.sv
package msr_trap_pkg;
  localparam int unsigned IDX_W  = 32;
  localparam int unsigned ADDR_W = 32;
  // index window span is 2**WIN_BITS entries, one bit each
  localparam int unsigned WIN_BITS = 13;
  localparam logic [IDX_W-1:0] HI_FIRST = 32'hC000_0000;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/msr_window_decode.sv
module msr_window_decode #(
  parameter int unsigned IDX_W    = msr_trap_pkg::IDX_W,
  parameter int unsigned WIN_BITS = msr_trap_pkg::WIN_BITS,
  parameter logic [IDX_W-1:0] HI_FIRST = msr_trap_pkg::HI_FIRST,
  localparam int unsigned OFF_W   = WIN_BITS - 3 + 2
) (
  input  logic [IDX_W-1:0] index_i,
  input  logic             is_write_i,
  output logic             in_lo_o,
  output logic             in_hi_o,
  output logic [OFF_W-1:0] byte_off_o,
  output logic [2:0]       bit_sel_o
);
  localparam logic [IDX_W-1:0] WIN_SPAN = IDX_W'(1) << WIN_BITS;

  logic [IDX_W-1:0] hi_rel;
  logic [IDX_W-1:0] rel;

  assign hi_rel  = index_i - HI_FIRST;
  assign in_lo_o = index_i < WIN_SPAN;
  assign in_hi_o = hi_rel < WIN_SPAN;
  assign rel     = in_hi_o ? hi_rel : index_i;

  // quarter select: direction is the top bit, window the next
  assign byte_off_o = {is_write_i, in_hi_o, rel[WIN_BITS-1:3]};
  assign bit_sel_o  = index_i[2:0];
endmodule

// File: rtl/msr_bit_pick.sv
module msr_bit_pick #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned SEL_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              hit_o
);
  logic [BYTE_W-1:0] onehot;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_mask
    assign onehot[g] = (sel_i == SEL_W'(g));
  end

  assign hit_o = |(onehot & byte_i);
endmodule

// File: rtl/msr_fetch_seq.sv
module msr_fetch_seq
  import msr_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = msr_trap_pkg::ADDR_W,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              enable_i,
  input  logic              in_window_i,
  input  logic [OFF_W-1:0]  byte_off_i,
  input  logic [2:0]        bit_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              mem_ack_i,
  input  logic              hit_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [2:0]        sel_q_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o
);
  fetch_state_e state_q;

  assign busy_o = (state_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      sel_q_o    <= '0;
      done_o     <= 1'b0;
      trap_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (!enable_i || !in_window_i) begin
              done_o <= 1'b1;
              trap_o <= 1'b1;
            end else begin
              state_q    <= ST_WAIT;
              mem_req_o  <= 1'b1;
              mem_addr_o <= base_i + ADDR_W'(byte_off_i);
              sel_q_o    <= bit_sel_i;
            end
          end
        end
        ST_WAIT: begin
          if (mem_ack_i) begin
            state_q   <= ST_IDLE;
            mem_req_o <= 1'b0;
            done_o    <= 1'b1;
            trap_o    <= hit_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msr_trap_filter.sv
module msr_trap_filter
  import msr_trap_pkg::*;
#(
  parameter int unsigned IW = msr_trap_pkg::IDX_W,
  parameter int unsigned AW = msr_trap_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [IW-1:0] index_i,
  input  logic          is_write_i,
  input  logic [AW-1:0] bitmap_base_i,
  input  logic          bitmaps_en_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic          trap_o
);
  localparam int unsigned OFF_W = WIN_BITS - 3 + 2;

  logic             in_lo, in_hi, hit, busy;
  logic [OFF_W-1:0] byte_off;
  logic [2:0]       bit_sel, sel_q;

  msr_window_decode #(
    .IDX_W(IW), .WIN_BITS(WIN_BITS), .HI_FIRST(IW'(HI_FIRST))
  ) i_decode (
    .index_i   (index_i),
    .is_write_i(is_write_i),
    .in_lo_o   (in_lo),
    .in_hi_o   (in_hi),
    .byte_off_o(byte_off),
    .bit_sel_o (bit_sel)
  );

  msr_bit_pick #(.BYTE_W(8)) i_pick (
    .byte_i(mem_rdata_i),
    .sel_i (sel_q),
    .hit_o (hit)
  );

  msr_fetch_seq #(.ADDR_W(AW), .OFF_W(OFF_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .enable_i   (bitmaps_en_i),
    .in_window_i(in_lo | in_hi),
    .byte_off_i (byte_off),
    .bit_sel_i  (bit_sel),
    .base_i     (bitmap_base_i),
    .mem_ack_i  (mem_ack_i),
    .hit_i      (hit),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .sel_q_o    (sel_q),
    .busy_o     (busy),
    .done_o     (done_o),
    .trap_o     (trap_o)
  );
endmodule

// File: rtl/msr_trap_filter_chk.sv
module msr_trap_filter_chk #(
  parameter int unsigned IW = 32,
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [IW-1:0] index_i,
  input logic          bitmaps_en_i,
  input logic          busy,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          done_o,
  input logic          trap_o
);
  logic outside;
  assign outside = (index_i > IW'(32'h0000_1FFF) && index_i < IW'(32'hC000_0000))
                 || index_i > IW'(32'hC000_1FFF);

  a_r1_disabled_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i && !bitmaps_en_i) |=> (done_o && trap_o && !mem_req_o));

  a_r6_outside_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i && bitmaps_en_i && outside) |=> (done_o && trap_o && !mem_req_o));

  a_r2_window_fetches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i && bitmaps_en_i && !outside) |=> (mem_req_o && !done_o));

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r7_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> (done_o && !mem_req_o));

  a_r8_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !mem_ack_i) |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

bind msr_trap_filter msr_trap_filter_chk #(.IW(IW), .AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .index_i     (index_i),
  .bitmaps_en_i(bitmaps_en_i),
  .busy        (busy),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .done_o      (done_o),
  .trap_o      (trap_o)
);

// File: tb/test_msr_trap_filter.sv
module test_msr_trap_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] index = '0;
  logic        is_wr = 1'b0;
  logic [31:0] base = 32'h0012_3000;
  logic        en = 1'b1;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        done, trap;

  always #4 clk = ~clk;

  msr_trap_filter i_msr_trap_filter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .index_i(index),
    .is_write_i(is_wr), .bitmap_base_i(base), .bitmaps_en_i(en),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .done_o(done), .trap_o(trap)
  );

  int tests = 0, fails = 0;
  int reads = 0, dones = 0, lat = 0;
  logic [7:0]  bmp [4096];
  bit          exp_trap_q [$];
  logic [31:0] exp_addr_q [$];
  string       tag_q [$];
  bit          finished = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // memory responder with adjustable latency
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        logic [31:0] a0, ea;
        a0 = mem_addr;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          check(mem_req && mem_addr == a0, "R7 req held", mem_addr, a0);
        end
        ea = (exp_addr_q.size() > 0) ? exp_addr_q.pop_front() : 32'hDEAD_BEEF;
        check(mem_addr == ea, tag_q.size() > 0 ? tag_q[0] : "R2 addr", mem_addr, ea);
        reads++;
        mem_rdata = bmp[12'(mem_addr - base)];
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        check(done == 1'b1 && mem_req == 1'b0, "R7 done after ack", {31'd0, done}, 32'd1);
      end
    end
  end

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && done) begin
      string t;
      dones++;
      t = (tag_q.size() > 0) ? tag_q.pop_front() : "R10 extra done";
      if (exp_trap_q.size() == 0)
        check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
      else begin
        bit e;
        e = exp_trap_q.pop_front();
        check(trap == e, t, {31'd0, trap}, {31'd0, e});
      end
    end
  end

  task automatic issue(logic [31:0] idx, bit wr, bit ena, string tag);
    bit in_lo, in_hi, e;
    logic [31:0] rel;
    logic [11:0] off;
    int r0, d0;
    in_lo = idx <= 32'h1FFF;
    in_hi = idx >= 32'hC000_0000 && idx <= 32'hC000_1FFF;
    rel   = in_hi ? idx - 32'hC000_0000 : idx;
    off   = 12'(rel >> 3) + (in_hi ? 12'd1024 : 12'd0) + (wr ? 12'd2048 : 12'd0);
    r0 = reads; d0 = dones;
    if (!ena || !(in_lo || in_hi)) e = 1'b1;
    else begin
      e = bmp[off][idx[2:0]];
      exp_addr_q.push_back(base + 32'(off));
    end
    exp_trap_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b1; index = idx; is_wr = wr; en = ena;
    @(negedge clk);
    req = 1'b0;
    while (dones == d0) @(negedge clk);
    @(negedge clk);
    if (!ena || !(in_lo || in_hi))
      check(reads == r0, {tag, " no read"}, reads - r0, 0);
    else
      check(reads == r0 + 1, {tag, " one read"}, reads - r0, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) bmp[i] = 8'((i * 29) + (i >> 4)) ^ 8'h5A;
    bmp[1]    = 8'h01;   // low read byte 1: index 8 traps, 9 does not
    bmp[1023] = 8'h80;   // index 0x1FFF traps
    bmp[1024] = 8'h00;   // high read byte 0: 0xC0000000 passes
    bmp[2047] = 8'h80;   // 0xC0001FFF traps
    bmp[2048] = 8'h00;   // low write byte 0: index 3 write passes
    bmp[0]    = 8'h08;   // low read byte 0: index 3 read traps
    repeat (3) @(negedge clk);
    check(done == 0 && trap == 0 && mem_req == 0, "R9 reset state",
          {29'd0, done, trap, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    issue(32'h0000_0010, 0, 0, "R1 disabled low");
    issue(32'hC000_0004, 1, 0, "R1 disabled high");
    issue(32'h0000_0008, 0, 1, "R5 bit set");
    issue(32'h0000_0009, 0, 1, "R5 bit clear");
    issue(32'h0000_0003, 0, 1, "R2 read idx3");
    issue(32'h0000_0003, 1, 1, "R4 write idx3");
    issue(32'h0000_1FFF, 0, 1, "R2 low top");
    issue(32'h0000_0155, 0, 1, "R2 mid");
    issue(32'hC000_0000, 0, 1, "R3 high first");
    issue(32'hC000_1FFF, 0, 1, "R3 high last");
    issue(32'hC000_0A3C, 1, 1, "R4 high write");
    issue(32'h0000_0777, 1, 1, "R4 low write");
    issue(32'h0000_2000, 0, 1, "R6 above low");
    issue(32'hBFFF_FFFF, 1, 1, "R6 below high");
    issue(32'hC000_2000, 0, 1, "R6 above high");
    issue(32'hFFFF_FFFF, 0, 1, "R6 top");
    base = 32'h0000_8A51;
    lat = 3;
    issue(32'h0000_0ABC, 0, 1, "R7 latency low");
    issue(32'hC000_1234, 1, 1, "R7 latency high");
    for (int i = 0; i < 8; i++) begin
      lat = i % 4;
      issue(32'(i * 613), i[0], 1, "R5 sweep");
    end
    // R8: second strobe during pending fetch must be ignored
    begin
      int r0, d0;
      lat = 4;
      r0 = reads; d0 = dones;
      exp_trap_q.push_back(bmp[12'(32'h0000_0040 >> 3)][0]);
      exp_addr_q.push_back(base + 32'h8);
      tag_q.push_back("R8 first result");
      @(negedge clk); req = 1; index = 32'h40; is_wr = 0; en = 1;
      @(negedge clk); req = 0;
      @(negedge clk); req = 1; index = 32'h2000; en = 1;
      @(negedge clk); req = 0;
      repeat (10) @(negedge clk);
      check(dones == d0 + 1, "R8 single done", dones - d0, 1);
      check(reads == r0 + 1, "R8 single read", reads - r0, 1);
    end
    check(exp_trap_q.size() == 0, "R10 all answered", exp_trap_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule